// File: doc/BRIEF.md
# Masked Priority Interrupt Vector Controller

This block gathers eight interrupt request lines from a small microcontroller's peripherals and raises a single interrupt line to the CPU. The peripherals are the power monitor (power-on / low-voltage), two external interrupt pins, the SPI transmit and receive paths, two GPIO ports and a sleep timer. A rising edge on any request line is latched as pending. An enable register decides which pending sources may reach the CPU.

Software reaches the block through an 8-bit register port with an address, a write strobe and write data. Read data is combinational from the address. The enable register sits at address 0xE0. The vector register sits at 0xE2. Reading the vector register gives a code that identifies the most urgent enabled pending source. Writing the vector register with any value discards every pending flag at once. The CPU's vector fetch, context stacking and nesting belong to the core, not to this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the vector register reads 0x00 and `irq_out` is low.
- R2: The enable register at address 0xE0 is written with `bus_wdata` and read back unchanged. Its bit-to-source mapping is:
  - bit 0: power-on / low-voltage
  - bit 1: external pin 0
  - bit 2: SPI transmit
  - bit 3: SPI receive
  - bit 4: GPIO port 0
  - bit 5: external pin 1
  - bit 6: sleep timer
  - bit 7: GPIO port 1
- R3: A 0-to-1 transition of `req_in[i]`, seen on one clock edge, sets pending flag i on that edge, even when enable bit i is 0. A request line held high does not set the flag again.
- R4: `irq_out` is registered. On each clock edge it takes the OR over all sources of (pending AND enable) as it stood before that edge.
- R5: The vector register at 0xE2 reads `4*i`, where i is the lowest-numbered source that is both pending and enabled. Source 0 has the highest priority and source 7 the lowest. The register reads 0x00 when no enabled source is pending.
- R6: A write to address 0xE2 clears all pending flags on that clock edge, whatever the data written.
- R7: When a clearing write and a new request edge on source i occur on the same clock edge, flag i stays set after that edge.
- R8: Any address other than 0xE0 and 0xE2 reads 0x00. Writes to such addresses change neither the enable register nor the pending flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| req_in | input | 8 | Request lines, one per source, synchronous to `clk` |
| irq_out | output | 1 | Interrupt line to the CPU |

## Verification
Two operations can land on the same clock edge: the clearing write to the vector register, and a fresh rising request edge. A directed step lines up a write to 0xE2 with a new edge on one source while another source is already pending. The vector readback on the next cycle must then show only the new source. Long random stretches also issue clearing writes while request lines toggle, and the cycle model in the bench judges the result on every clock. A request held high through a clear confirms that only edges, not levels, set a flag again.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Source numbering; a lower number wins arbitration.
  typedef enum int unsigned {
    SRC_PWR    = 0,
    SRC_EXT0   = 1,
    SRC_SPI_TX = 2,
    SRC_SPI_RX = 3,
    SRC_PORT0  = 4,
    SRC_EXT1   = 5,
    SRC_SLEEP  = 6,
    SRC_PORT1  = 7
  } irq_src_e;

  // Vector code for a winning source: index scaled by 2**shift.
  function automatic logic [7:0] vec_code(input int unsigned idx, input int unsigned shift);
    return 8'(idx << shift);
  endfunction

  // Rising edge of a request vector given its previous sample.
  function automatic logic [31:0] rise_of(input logic [31:0] now_v, input logic [31:0] prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  output logic [NSRC-1:0] rise
);
  import irq_vec_pkg::*;

  logic [NSRC-1:0] prev_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= req_in[g];
    end
  end

  always_comb begin
    logic [31:0] r32;
    r32  = rise_of(32'(req_in), 32'(prev_q));
    rise = r32[NSRC-1:0];
  end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise,
  input  logic            clr_all,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  // A new edge overrides the clear on the same edge.
  always_comb pend_d = (clr_all ? '0 : pend_q) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R6: a clear with no fresh edge leaves nothing pending
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && rise == '0) |=> (pend == '0));

  // R3 / R7: every fresh edge is pending afterwards, clear or not
  assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

  // R3: without clear, a flag never drops
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all) |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int NSRC = 8,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] active,
  output logic            found,
  output logic [IDXW-1:0] win_idx
);

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        found   = 1'b1;
        win_idx = IDXW'(i);
      end
    end
  end

  // R5: the winner is active and nothing below it is
  assert_winner_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> active[win_idx]);
  assert_winner_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((active & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0));
  assert_none_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (!found && win_idx == '0));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int            NSRC      = 8,
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter int            VEC_SHIFT = 2,
  parameter logic [AW-1:0] MASK_ADDR = 8'hE0,
  parameter logic [AW-1:0] VEC_ADDR  = 8'hE2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr_en,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] req_in,
  output logic            irq_out
);
  import irq_vec_pkg::*;

  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] active;
  logic            wr_mask;
  logic            clr_all;
  logic            found;
  logic [IDXW-1:0] win_idx;
  logic [DW-1:0]   vec_val;
  logic            irq_q;

  assign wr_mask = bus_wr_en && (bus_addr == MASK_ADDR);
  assign clr_all = bus_wr_en && (bus_addr == VEC_ADDR);

  irq_edge_detect #(.NSRC(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in (req_in),
    .rise   (rise)
  );

  irq_pending_bank #(.NSRC(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .clr_all (clr_all),
    .pend    (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata[NSRC-1:0];
  end

  assign active = pend & mask_q;

  irq_prio_encoder #(.NSRC(NSRC), .IDXW(IDXW)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .found   (found),
    .win_idx (win_idx)
  );

  always_comb begin
    vec_val = '0;
    if (found) vec_val = DW'(vec_code(int'(win_idx), VEC_SHIFT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |active;
  end
  assign irq_out = irq_q;

  always_comb begin
    if (bus_addr == MASK_ADDR)     bus_rdata = DW'(mask_q);
    else if (bus_addr == VEC_ADDR) bus_rdata = vec_val;
    else                           bus_rdata = '0;
  end

  // R2: the enable register takes the written data
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata[NSRC-1:0])));

  // R8: writes elsewhere leave the enable register alone
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask) |=> $stable(mask_q));

  // R4: output follows enabled pending one edge later
  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & mask_q)) |=> irq_out);
  assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(pend & mask_q))) |=> !irq_out);

endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] req_in = 8'h00;
  logic       irq_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_in    (req_in),
    .irq_out   (irq_out)
  );

  // Behavioural reference: integer arrays, updated per clock edge.
  int m_prev [8];
  int m_pend [8];
  int m_mask [8];
  int m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_prev[i] = 0; m_pend[i] = 0; m_mask[i] = 0;
      end
      m_irq = 0;
    end else begin
      int any_act;
      any_act = 0;
      for (int i = 0; i < 8; i++) if (m_pend[i] != 0 && m_mask[i] != 0) any_act = 1;
      m_irq = any_act;
      for (int i = 0; i < 8; i++) begin
        int edge_now;
        edge_now = (req_in[i] && m_prev[i] == 0) ? 1 : 0;
        if (bus_wr_en && bus_addr == 8'hE2) m_pend[i] = 0;
        if (edge_now != 0) m_pend[i] = 1;
        m_prev[i] = req_in[i] ? 1 : 0;
        if (bus_wr_en && bus_addr == 8'hE0) m_mask[i] = bus_wdata[i] ? 1 : 0;
      end
    end
  end

  function automatic int model_read(input logic [7:0] a);
    int r;
    r = 0;
    if (a == 8'hE0) begin
      for (int i = 0; i < 8; i++) if (m_mask[i] != 0) r += (1 << i);
    end else if (a == 8'hE2) begin
      for (int i = 7; i >= 0; i--) if (m_pend[i] != 0 && m_mask[i] != 0) r = i * 4;
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One clock; compare against the model at the falling edge.
  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      check("R4 irq_out", int'(irq_out), m_irq);
      if (bus_addr == 8'hE0)      check("R2 enable readback", int'(bus_rdata), model_read(bus_addr));
      else if (bus_addr == 8'hE2) check("R5 vector readback", int'(bus_rdata), model_read(bus_addr));
      else                        check("R8 unmapped read", int'(bus_rdata), model_read(bus_addr));
    end
  endtask

  task automatic idle(input logic [7:0] a);
    bus_wr_en = 1'b0; bus_addr = a;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished by cycle 100000");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle(8'hE0); tick(); check("R1 enable after reset", int'(bus_rdata), 0);
    check("R1 irq after reset", int'(irq_out), 0);
    idle(8'hE2); tick(); check("R1 vector after reset", int'(bus_rdata), 0);

    // R3: edge while masked still pends, but nothing is signalled
    req_in = 8'h20; idle(8'hE2); tick();
    check("R3 masked pend hidden", int'(bus_rdata), 0);
    tick(); check("R3 masked no irq", int'(irq_out), 0);
    wr(8'hE0, 8'hFF); tick(); idle(8'hE2); tick();
    check("R3 masked edge was latched", int'(bus_rdata), 8'h14);
    check("R4 irq after unmask", int'(irq_out), 1);

    // R5: priority between sources 3 and 5
    req_in = 8'h28; tick();
    check("R5 lower index wins", int'(bus_rdata), 8'h0C);
    // R2: bit 3 disabled leaves source 5 as winner
    wr(8'hE0, 8'hF7); tick(); idle(8'hE2); tick();
    check("R2 bit3 disable", int'(bus_rdata), 8'h14);

    // R6: clear with arbitrary data, request lines held high
    wr(8'hE2, 8'h5A); tick(); idle(8'hE2); tick();
    check("R6 cleared vector", int'(bus_rdata), 0);
    tick(); check("R3 held level no retrigger", int'(bus_rdata), 0);
    check("R6 irq dropped", int'(irq_out), 0);

    // R7: clear and new edge on source 0 in the same cycle, source 6 pending
    req_in = 8'h00; wr(8'hE0, 8'hFF); tick();
    req_in = 8'h40; idle(8'hE2); tick();
    req_in = 8'h41; wr(8'hE2, 8'h00); tick(); idle(8'hE2); tick();
    check("R7 edge survives clear", int'(bus_rdata), 8'h00);
    check("R7 irq kept", int'(irq_out), 1);
    req_in = 8'h00; wr(8'hE2, 8'hFF); tick(); idle(8'hE2); tick();
    req_in = 8'h80; tick(); tick();
    check("R5 lowest priority alone", int'(bus_rdata), 8'h1C);

    // R8: unmapped write and read
    wr(8'hE1, 8'h00); tick(); wr(8'h00, 8'h00); tick(); idle(8'hE3); tick();
    check("R8 unmapped reads zero", int'(bus_rdata), 0);
    idle(8'hE0); tick(); check("R8 enable untouched", int'(bus_rdata), 8'hFF);
    idle(8'hE2); tick(); check("R8 pending untouched", int'(bus_rdata), 8'h1C);

    // Random traffic, model compared every cycle.
    for (int n = 0; n < 4000; n++) begin
      int sel;
      req_in = 8'($urandom);
      sel = int'($urandom % 6);
      bus_addr = (sel == 0) ? 8'hE0 : (sel == 1) ? 8'hE1 : (sel == 2) ? 8'h00 : 8'hE2;
      bus_wr_en = (($urandom % 5) == 0);
      bus_wdata = 8'($urandom);
      tick();
    end
    idle(8'hE2); tick();
    summary();
  end

endmodule